// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a processor core and up to 22 interrupt sources. Each maskable source delivers a level request that has already been gated by that source's own flag and enable bit. The controller holds one global mask bit. When the mask is clear, the controller picks the pending request with the lowest interrupt number. It offers that request to the core together with the address of the vector-table word that holds the handler pointer. The table sits at the top of the 16-bit address space: interrupt number n maps to 0xFFFE - 2n. Some examples are the periodic real-time source (7) at 0xFFF0, compare channel 0 (8) at 0xFFEE, and the serial ports (20, 21) at 0xFFD6 and 0xFFD4.

Three fixed entries are never masked: reset (0), the trap (3) and the software interrupt (4). After reset the first offer is always the reset entry. A request is sampled only on an instruction-boundary strobe, so the current instruction completes first. The offer is a valid/ready stream. Once `offer_valid` rises, the number and address stay fixed until the core raises `offer_ready`. The core may hold `offer_ready` low for as long as it likes. No new request is sampled while an offer is outstanding.

Accepting an offer sets the global mask, so a second maskable request cannot preempt the handler. A return strobe restores the mask value from before entry. While the mask is set, maskable requests wait; they are not dropped.

Top module: `ivc_top`

## Requirements
- R1: After reset `gmask` reads 1, and the first offer is number 0 at address 0xFFFE, made even though the mask is 1.
- R2: A new offer is formed only on a clock edge where `instr_done` is 1 and no offer is outstanding; without `instr_done`, pending requests produce no offer.
- R3: A maskable request (`src_req` bit n, n not 0, 3 or 4) is offered only if `gmask` is 0 at the sampling edge; with the mask at 1 it stays pending and is offered after the mask is cleared.
- R4: Among all requests eligible together, the lowest interrupt number is offered.
- R5: `offer_addr` equals 0xFFFE - 2 x `offer_num` (7 gives 0xFFF0, 8 gives 0xFFEE, 20 gives 0xFFD6, 21 gives 0xFFD4).
- R6: While `offer_valid` is 1 and `offer_ready` is 0, the offer stays valid and its number and address do not change, even if a higher-priority request appears.
- R7: The edge where `offer_valid` and `offer_ready` are both 1 clears `offer_valid` and sets `gmask` to 1.
- R8: A `ret_strobe` restores `gmask` to its value just before the most recent acceptance.
- R9: The trap request (number 3, address 0xFFF8) and the software interrupt request (number 4, address 0xFFF6) are offered whatever the value of `gmask`.
- R10: `src_req` bits 0, 3 and 4 are ignored; those numbers come only from reset, `trap_req` and `swi_req`.
- R11: `mask_wr` loads `mask_din` into `gmask`; on the same edge an acceptance takes precedence over `ret_strobe`, which takes precedence over `mask_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 22 | Gated level requests, bit n is interrupt number n |
| trap_req | input | 1 | Trap request level (number 3), held until accepted |
| swi_req | input | 1 | Software interrupt level (number 4), held until accepted |
| instr_done | input | 1 | Instruction boundary strobe |
| mask_wr | input | 1 | Global mask write strobe |
| mask_din | input | 1 | Value written to the global mask |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| offer_valid | output | 1 | An interrupt offer is presented |
| offer_ready | input | 1 | Core accepts the offer |
| offer_num | output | 5 | Offered interrupt number |
| offer_addr | output | 16 | Vector fetch address of the offer |
| gmask | output | 1 | Current global mask bit |

## Verification
The hardest case to reach is a higher-priority request that arrives while an older offer is stalled. Under R6 the stalled offer must not be replaced. The bench gets there by posting a low-priority source, holding `offer_ready` low across several boundary strobes, and then raising a lower-numbered source. A second hard case is a maskable request that waits under the mask and is then released by a return strobe rather than by a mask write. The bench reaches it by accepting one source, raising another during the handler, and checking that the second is offered only after `ret_strobe`.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC      = 22;
  localparam int NUMW      = $clog2(NSRC);
  localparam int ADDRW     = 16;
  localparam int RESET_NUM = 0;
  localparam int TRAP_NUM  = 3;
  localparam int SWI_NUM   = 4;
  localparam logic [ADDRW-1:0] VEC_TOP = 16'hFFFE;

  function automatic logic [ADDRW-1:0] vec_addr(input logic [NUMW-1:0] n);
    return VEC_TOP - {{(ADDRW-NUMW-1){1'b0}}, n, 1'b0};
  endfunction

  function automatic logic is_fixed(input logic [NUMW-1:0] n);
    return (n == NUMW'(RESET_NUM)) || (n == NUMW'(TRAP_NUM)) || (n == NUMW'(SWI_NUM));
  endfunction
endpackage

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int N = 22,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_mask.sv
module ivc_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic ret,
  input  logic wr,
  input  logic din,
  output logic mask_q
);
  logic saved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      saved_q <= 1'b1;
    end else if (take) begin
      saved_q <= mask_q;
      mask_q  <= 1'b1;
    end else if (ret) begin
      mask_q  <= saved_q;
    end else if (wr) begin
      mask_q  <= din;
    end
  end

  AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !take |=> mask_q == $past(saved_q)); // R8
  AST_TAKE_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> saved_q == $past(mask_q)); // R8
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !take && !ret |=> mask_q == $past(din)); // R11
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int N = NSRC,
  localparam int W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_req,
  input  logic             trap_req,
  input  logic             swi_req,
  input  logic             instr_done,
  input  logic             mask_wr,
  input  logic             mask_din,
  input  logic             ret_strobe,
  output logic             offer_valid,
  input  logic             offer_ready,
  output logic [W-1:0]     offer_num,
  output logic [ADDRW-1:0] offer_addr,
  output logic             gmask
);
  localparam logic [N-1:0] FIXED_BITS =
    (N'(1) << RESET_NUM) | (N'(1) << TRAP_NUM) | (N'(1) << SWI_NUM);

  logic         rst_pend_q;
  logic [N-1:0] eligible;
  logic         cand_hit;
  logic [W-1:0] cand_idx;
  logic         take;
  logic         capture;

  always_comb begin
    eligible = gmask ? '0 : (src_req & ~FIXED_BITS);
    eligible[RESET_NUM] = rst_pend_q;
    eligible[TRAP_NUM]  = trap_req;
    eligible[SWI_NUM]   = swi_req;
  end

  ivc_prio #(.N(N)) u_prio (
    .req (eligible),
    .hit (cand_hit),
    .idx (cand_idx)
  );

  assign take    = offer_valid && offer_ready;
  assign capture = !offer_valid && instr_done && cand_hit;

  ivc_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .ret    (ret_strobe),
    .wr     (mask_wr),
    .din    (mask_din),
    .mask_q (gmask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_valid <= 1'b0;
      offer_num   <= '0;
      offer_addr  <= VEC_TOP;
      rst_pend_q  <= 1'b1;
    end else if (take) begin
      offer_valid <= 1'b0;
      if (offer_num == W'(RESET_NUM)) rst_pend_q <= 1'b0;
    end else if (capture) begin
      offer_valid <= 1'b1;
      offer_num   <= cand_idx;
      offer_addr  <= vec_addr(cand_idx);
    end
  end

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_num) && $stable(offer_addr)); // R6
  AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && offer_ready |=> !offer_valid && gmask); // R7
  AST_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (32'(offer_addr) + 32'(offer_num) * 2) == 32'hFFFE); // R5
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(offer_valid) && !is_fixed(offer_num) |-> !$past(gmask)); // R3
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(offer_valid) |-> $past(instr_done)); // R2
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend_q && offer_valid |-> offer_num == W'(RESET_NUM)); // R1
endmodule

// File: tb/ivc_top_tb.sv
module ivc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] src_req;
  logic        trap_req, swi_req, instr_done, mask_wr, mask_din, ret_strobe;
  logic        offer_valid, offer_ready, gmask;
  logic [4:0]  offer_num;
  logic [15:0] offer_addr;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ivc_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_req(trap_req),
    .swi_req(swi_req), .instr_done(instr_done), .mask_wr(mask_wr),
    .mask_din(mask_din), .ret_strobe(ret_strobe), .offer_valid(offer_valid),
    .offer_ready(offer_ready), .offer_num(offer_num), .offer_addr(offer_addr),
    .gmask(gmask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    instr_done = 1'b1; @(negedge clk); instr_done = 1'b0;
  endtask
  task automatic accept();
    offer_ready = 1'b1; @(negedge clk); offer_ready = 1'b0;
  endtask
  task automatic ret();
    ret_strobe = 1'b1; @(negedge clk); ret_strobe = 1'b0;
  endtask
  task automatic wmask(input logic v);
    mask_wr = 1'b1; mask_din = v; @(negedge clk); mask_wr = 1'b0;
  endtask
  task automatic expect_offer(input string req, input int n, input logic [15:0] a);
    chk(req, 32'(offer_valid), 1);
    chk(req, 32'(offer_num), 32'(n));
    chk(req, 32'(offer_addr), 32'(a));
  endtask

  task automatic t_reset();
    chk("R1 mask after reset", 32'(gmask), 1);
    chk("R2 no offer before boundary", 32'(offer_valid), 0);
    src_req = 22'h000100;
    step();
    expect_offer("R1 reset vector", 0, 16'hFFFE);
    accept();
    chk("R7 valid drops", 32'(offer_valid), 0);
    chk("R7 mask set", 32'(gmask), 1);
    src_req = '0;
  endtask

  task automatic t_postpone();
    src_req = 22'h000100;
    step();
    chk("R3 masked postponed", 32'(offer_valid), 0);
    wmask(1'b0);
    chk("R11 mask write", 32'(gmask), 0);
    @(negedge clk);
    chk("R2 no boundary no offer", 32'(offer_valid), 0);
    step();
    expect_offer("R3 R5 ch0 offered", 8, 16'hFFEE);
    accept();
    src_req = '0;
    ret();
    chk("R8 restore to 0", 32'(gmask), 0);
  endtask

  task automatic t_priority_hold();
    src_req = (22'h1 << 16) | (22'h1 << 20) | (22'h1 << 7);
    step();
    expect_offer("R4 R5 lowest wins", 7, 16'hFFF0);
    src_req = src_req | (22'h1 << 2);
    step(); step();
    expect_offer("R6 held while stalled", 7, 16'hFFF0);
    accept();
    src_req = (22'h1 << 16) | (22'h1 << 20) | (22'h1 << 2);
    step();
    chk("R7 no nesting", 32'(offer_valid), 0);
    ret();
    step();
    expect_offer("R8 R4 released by return", 2, 16'hFFFA);
    accept(); ret();
    src_req = (22'h1 << 21) | (22'h1 << 20);
    step();
    expect_offer("R5 serial 20", 20, 16'hFFD6);
    accept(); ret();
    src_req = (22'h1 << 21);
    step();
    expect_offer("R5 serial 21", 21, 16'hFFD4);
    accept(); ret();
    src_req = '0;
  endtask

  task automatic t_fixed();
    src_req = 22'b11001;
    step();
    chk("R10 fixed bits ignored", 32'(offer_valid), 0);
    src_req = '0;
    wmask(1'b1);
    trap_req = 1'b1; swi_req = 1'b1;
    step();
    expect_offer("R9 trap under mask", 3, 16'hFFF8);
    accept(); trap_req = 1'b0;
    step();
    expect_offer("R9 swi under mask", 4, 16'hFFF6);
    accept(); swi_req = 1'b0;
    ret();
    chk("R8 restore to 1", 32'(gmask), 1);
  endtask

  task automatic t_precedence();
    wmask(1'b0);
    src_req = (22'h1 << 9);
    step();
    src_req = '0;
    offer_ready = 1'b1; ret_strobe = 1'b1; mask_wr = 1'b1; mask_din = 1'b0;
    @(negedge clk);
    offer_ready = 1'b0; ret_strobe = 1'b0;
    chk("R11 accept beats return and write", 32'(gmask), 1);
    @(negedge clk);
    mask_wr = 1'b0;
    chk("R11 write applies alone", 32'(gmask), 0);
    wmask(1'b1);
    ret_strobe = 1'b1; mask_wr = 1'b1; mask_din = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0; mask_wr = 1'b0;
    chk("R11 return beats write", 32'(gmask), 0);
  endtask

  initial begin
    rst_n = 1'b0; src_req = '0; trap_req = 1'b0; swi_req = 1'b0;
    instr_done = 1'b0; mask_wr = 1'b0; mask_din = 1'b0; ret_strobe = 1'b0;
    offer_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_postpone();
    t_priority_hold();
    t_fixed();
    t_precedence();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule